// File: doc/BRIEF.md
# I2C Slave Receiver with Clock Stretching

This block is a receive-only I2C slave with 7-bit addressing. It brings the SCL and SDA bus lines into the system clock domain, spots start and stop conditions, and compares the first byte after each start with a programmed own address. When the address matches and the direction bit says write, it takes in data bytes, returns a programmable acknowledge level in the ninth clock of each frame, and places each byte in a receive data register with a full flag.

The local side reads a byte by pulsing a read strobe, which clears the full flag. If a byte is still unread when the next frame reaches its eighth falling SCL edge, the block holds SCL low until the read comes. This means no byte is ever overwritten. The acknowledge level is captured once per frame, so a change on that input applies from the next frame on. The block drives the bus only through two open-drain pull-low enables.

Top module: `i2c_slave_rx`

## Requirements
- R1: While enable_i is 0 the block never pulls SCL or SDA low and never sets rx_full_o.
- R2: A start condition (SDA falling while SCL is high) begins an address frame. Its first byte is taken MSB first: bits 7..1 are the address and bit 0 is the direction, where 0 means write. Data frames follow only when bits 7..1 equal own_addr_i and bit 0 is 0.
- R3: In an accepted frame, SDA is pulled low from the 8th SCL falling edge to the 9th SCL falling edge when the captured acknowledge level is 0 (ACK). It is left released when that level is 1 (NACK).
- R4: At the 9th SCL rising edge of an accepted frame, the received byte is loaded into rx_data_o and rx_full_o becomes 1. In the address frame the loaded byte is {address, 0}.
- R5: A pulse on rd_strobe_i clears rx_full_o. The last byte of a transfer is read the same way as any other byte.
- R6: If rx_full_o is 1 at the 8th SCL falling edge of an accepted frame, scl_drive_low_o rises and stays 1 until rd_strobe_i is pulsed. It is released on the next clock edge after the pulse.
- R7: ack_nack_i is sampled at the first SCL rising edge of each frame. A change made later in the frame applies from the next frame.
- R8: On an address mismatch, or a matching address with direction bit 1, there is no acknowledge and no load. All traffic is ignored until the next start condition.
- R9: A stop condition (SDA rising while SCL is high) releases both lines and returns the block to idle. SCL pulses that follow without a new start are ignored.
- R10: A repeated start inside a transfer restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Enables participation on the bus |
| own_addr_i | input | 7 | Own 7-bit slave address |
| ack_nack_i | input | 1 | Acknowledge level: 0 = ACK (pull SDA low), 1 = NACK |
| rd_strobe_i | input | 1 | One-cycle read pulse; clears the full flag |
| scl_i | input | 1 | SCL bus line level |
| sda_i | input | 1 | SDA bus line level |
| scl_drive_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low_o | output | 1 | Pull SDA low (acknowledge) |
| rx_data_o | output | 8 | Receive data register |
| rx_full_o | output | 1 | Receive data register holds an unread byte |

## Verification
The receive path is exercised with these address frames:
- a matching write address, which must produce both the acknowledge and the dummy load;
- a matching address with the read bit set;
- a foreign address;
- a repeated start that switches from a foreign to a matching address.

Together these separate a correct comparison from one that ignores the direction bit or does not restart the address phase.

Data bytes are sent in four ways:
- read in time, which shows the normal load;
- left unread, which must trigger the stretch and be released only by the read;
- with the acknowledge level toggled mid-frame, which shows whether the level is captured per frame;
- without a start after a stop, which shows whether the block really returned to idle.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } srx_state_e;
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  // bus idles high, so reset to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '1;
    else         pipe_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '1;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_srx_cond.sv
module i2c_srx_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_srx_frame.sv
module i2c_srx_frame
  import i2c_srx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_nack_i,
  input  logic              rd_strobe_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_drv_o,
  output logic              scl_hold_o,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W + 1);

  srx_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shift_q, data_q;
  logic              full_q, ack_lvl_q, accept_q, sda_drv_q, scl_hold_q;
  logic              addr_hit, accept_now, active;

  always_comb begin
    addr_hit   = (shift_q[DATA_W-1 -: ADDR_W] == own_addr_i) && !shift_q[0];
    accept_now = (state_q == ST_DATA) || ((state_q == ST_ADDR) && addr_hit);
    active     = (state_q == ST_ADDR) || (state_q == ST_DATA);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shift_q    <= '0;
      data_q     <= '0;
      full_q     <= 1'b0;
      ack_lvl_q  <= 1'b0;
      accept_q   <= 1'b0;
      sda_drv_q  <= 1'b0;
      scl_hold_q <= 1'b0;
    end else begin
      if (rd_strobe_i) begin
        full_q     <= 1'b0;
        scl_hold_q <= 1'b0;
      end
      if (!enable_i) begin
        state_q    <= ST_IDLE;
        cnt_q      <= '0;
        accept_q   <= 1'b0;
        sda_drv_q  <= 1'b0;
        scl_hold_q <= 1'b0;
      end else if (start_i) begin
        state_q   <= ST_ADDR;
        cnt_q     <= '0;
        accept_q  <= 1'b0;
        sda_drv_q <= 1'b0;
      end else if (stop_i) begin
        state_q    <= ST_IDLE;
        cnt_q      <= '0;
        accept_q   <= 1'b0;
        sda_drv_q  <= 1'b0;
        scl_hold_q <= 1'b0;
      end else if (active) begin
        if (scl_rise_i) begin
          if (cnt_q == '0) ack_lvl_q <= ack_nack_i;  // per-frame capture
          if (cnt_q < LAST_BIT) begin
            shift_q <= {shift_q[DATA_W-2:0], sda_s_i};
            cnt_q   <= cnt_q + 1'b1;
          end else if (cnt_q == LAST_BIT) begin
            cnt_q <= ACK_BIT;
            if (accept_q) begin
              data_q <= shift_q;
              full_q <= 1'b1;
            end
          end
        end
        if (scl_fall_i) begin
          if (cnt_q == LAST_BIT) begin
            accept_q  <= accept_now;
            sda_drv_q <= accept_now && !ack_lvl_q;
            if (accept_now && full_q && !rd_strobe_i) scl_hold_q <= 1'b1;
            if (!accept_now) state_q <= ST_SKIP;
          end else if (cnt_q == ACK_BIT) begin
            sda_drv_q <= 1'b0;
            cnt_q     <= '0;
            if (state_q == ST_ADDR) state_q <= ST_DATA;
          end
        end
      end
    end
  end

  assign sda_drv_o  = sda_drv_q;
  assign scl_hold_o = scl_hold_q;
  assign data_o     = data_q;
  assign full_o     = full_q;

  p_ack_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_drv_q |-> accept_q && (cnt_q == LAST_BIT || cnt_q == ACK_BIT));

  p_load_on_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(scl_rise_i) && $past(accept_q));

  p_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i && !scl_rise_i |=> !full_q);

  p_hold_needs_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_hold_q) |-> full_q);

  p_hold_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i |=> !scl_hold_q);

  p_skip_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SKIP |-> !sda_drv_q && !scl_hold_q);

  p_stop_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && enable_i |=> state_q == ST_IDLE && !sda_drv_q && !scl_hold_q);

  p_restart_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && enable_i |=> state_q == ST_ADDR && cnt_q == '0);
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_nack_i,
  input  logic              rd_strobe_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low_o,
  output logic              sda_drive_low_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o
);
  logic [1:0] line_s;
  logic       scl_rise, scl_fall, start_det, stop_det;

  i2c_srx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (line_s)
  );

  i2c_srx_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (line_s[1]),
    .sda_s_i    (line_s[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_srx_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .own_addr_i  (own_addr_i),
    .ack_nack_i  (ack_nack_i),
    .rd_strobe_i (rd_strobe_i),
    .sda_s_i     (line_s[0]),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .sda_drv_o   (sda_drive_low_o),
    .scl_hold_o  (scl_drive_low_o),
    .data_o      (rx_data_o),
    .full_o      (rx_full_o)
  );

  p_quiet_when_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !sda_drive_low_o && !scl_drive_low_o);

  p_no_fill_when_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i && !rx_full_o |=> !rx_full_o);
endmodule

// File: tb/i2c_slave_rx_tb.sv
module i2c_slave_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic ack_nack = 1'b0;
  logic rd = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic scl_drv, sda_drv, full;
  logic [7:0] data;
  wire scl_line = m_scl & ~scl_drv;
  wire sda_line = m_sda & ~sda_drv;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_slave_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .own_addr_i(OWN),
    .ack_nack_i(ack_nack), .rd_strobe_i(rd), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low_o(scl_drv), .sda_drive_low_o(sda_drv),
    .rx_data_o(data), .rx_full_o(full)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wcyc(Q);
    scl_up(); wcyc(Q);
    m_sda = 1'b0; wcyc(Q);
    m_scl = 1'b0; wcyc(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wcyc(Q);
    scl_up(); wcyc(Q);
    m_sda = 1'b1; wcyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked,
                           input int flip_at = -1, input logic flip_val = 1'b0);
    if (m_scl) begin m_scl = 1'b0; wcyc(Q); end
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wcyc(Q);
      scl_up();
      if (7 - i == flip_at) ack_nack = flip_val;
      wcyc(Q);
      m_scl = 1'b0; wcyc(Q);
    end
    m_sda = 1'b1; wcyc(Q);
    scl_up(); wcyc(Q/2);
    acked = !sda_line;
    wcyc(Q/2);
    m_scl = 1'b0; wcyc(Q);
  endtask

  task automatic do_read();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "reset sda drive", sda_drv, 0);
    chk("R1", "reset scl drive", scl_drv, 0);
    chk("R1", "reset full", full, 0);
  endtask

  task automatic t_disabled();
    bit a;
    enable = 1'b0;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    chk("R1", "no ack when disabled", a, 0);
    chk("R1", "no full when disabled", full, 0);
    bus_stop();
    enable = 1'b1;
    wcyc(4);
  endtask

  task automatic t_basic_write();
    bit a;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    chk("R2", "address ack", a, 1);
    chk("R4", "dummy full", full, 1);
    chk("R4", "dummy byte", data, {OWN, 1'b0});
    do_read();
    chk("R5", "full cleared", full, 0);
    send_byte(8'hA5, a);
    chk("R3", "data ack", a, 1);
    chk("R4", "data byte", data, 8'hA5);
    chk("R4", "data full", full, 1);
    do_read();
    send_byte(8'h3C, a);
    chk("R5", "last byte", data, 8'h3C);
    do_read();
    chk("R5", "last byte full cleared", full, 0);
    bus_stop();
    chk("R9", "sda released after stop", sda_drv, 0);
    chk("R9", "scl released after stop", scl_drv, 0);
  endtask

  task automatic t_rejects();
    bit a;
    bus_start();
    send_byte({OWN, 1'b1}, a);
    chk("R8", "read bit no ack", a, 0);
    chk("R8", "read bit no load", full, 0);
    bus_stop();
    bus_start();
    send_byte({7'h11, 1'b0}, a);
    chk("R8", "foreign address no ack", a, 0);
    send_byte(8'h99, a);
    chk("R8", "ignored data no ack", a, 0);
    chk("R8", "ignored data no load", full, 0);
    bus_start();
    send_byte({OWN, 1'b0}, a);
    chk("R10", "repeated start ack", a, 1);
    chk("R10", "repeated start load", data, {OWN, 1'b0});
    do_read();
    send_byte(8'h42, a);
    chk("R10", "data after restart", data, 8'h42);
    do_read();
    bus_start();
    send_byte({7'h55, 1'b0}, a);
    chk("R10", "restart to foreign no ack", a, 0);
    send_byte(8'h17, a);
    chk("R10", "restart to foreign no load", full, 0);
    bus_stop();
  endtask

  task automatic t_ack_level();
    bit a;
    ack_nack = 1'b1;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    chk("R3", "nack on address", a, 0);
    chk("R4", "nack address still loads", full, 1);
    do_read();
    ack_nack = 1'b0;
    send_byte(8'h5A, a);
    chk("R3", "ack after level change", a, 1);
    do_read();
    send_byte(8'h66, a, 3, 1'b1);
    chk("R7", "mid-frame change not applied", a, 1);
    do_read();
    send_byte(8'h6B, a, 3, 1'b0);
    chk("R7", "change applied next frame", a, 0);
    chk("R7", "nack frame loads", data, 8'h6B);
    do_read();
    bus_stop();
  endtask

  task automatic t_stretch();
    bit a, a2;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    do_read();
    send_byte(8'h11, a);
    fork
      send_byte(8'h22, a2);
      begin
        for (int i = 0; i < 2000 && !scl_drv; i++) @(negedge clk);
        chk("R6", "stretch asserted", scl_drv, 1);
        wcyc(50);
        chk("R6", "stretch held", scl_drv, 1);
        chk("R6", "old byte kept", data, 8'h11);
        chk("R6", "scl line low", scl_line, 0);
        do_read();
        chk("R6", "stretch released", scl_drv, 0);
      end
    join
    chk("R6", "stretched byte ack", a2, 1);
    chk("R6", "stretched byte loaded", data, 8'h22);
    chk("R6", "stretched full", full, 1);
    do_read();
    bus_stop();
  endtask

  task automatic t_after_stop();
    bit a;
    send_byte(8'h77, a);
    chk("R9", "no ack without start", a, 0);
    chk("R9", "no load without start", full, 0);
    m_sda = 1'b1; wcyc(Q);
    scl_up(); wcyc(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL ALL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wcyc(5);
    t_reset();
    rst_n = 1'b1;
    wcyc(5);
    t_reset();
    t_disabled();
    t_basic_write();
    t_rejects();
    t_ack_level();
    t_stretch();
    t_after_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule